// File: doc/BRIEF.md
# IDE Access Timing Generator

This block turns host accesses that land in a card's IDE register windows into IDE bus cycles. It decodes four 256-byte windows onto two IDE ports, each with two register sets. For each access it drives the matching active-low chip select, the three-bit device register address and an active-low read or write strobe. The select length and the delay before the strobe starts are both counted in bus clocks of about 70.5 ns. A three-bit speed mode picks them from a table of eight timings.

The speed mode is held in a byte-wide register inside the card's address space, and the host can read it and write it. Accesses whose host address has bit 6 set skip the table and always use a fixed slow timing, which suits byte-wide command traffic. The host sees a one-clock done pulse when the IDE cycle ends. On reads, the IDE data is captured on that same edge. A new access starts only after the host has dropped its strobe from the previous one.

Top module: `ide_strobe_gen`

## Requirements
- R1: During and after reset, every chip select and both strobes are high (inactive), host_done is low, and the speed mode is 0, so a read of the speed register returns 8'h1F.
- R2: The speed register sits at card offset 12'h7FE. A write stores host_wdata[7:5] as the mode. A read returns {mode, 5'b11111} on host_rdata[7:0] with zeros above. host_done pulses in the clock right after the start edge.
- R3: A window access holds its select for L clocks and starts the strobe after D clocks, where mode 0..7 gives (L,D) = (7,2), (9,3), (11,4), (5,1), (5,2), (5,3), (15,4), (5,1).
- R4: Once the strobe is asserted it stays asserted until the end of the access, and it deasserts on the same edge as the select. It is asserted only while a select is asserted.
- R5: Offsets 12'h8xx, 9xx, Axx and Bxx assert ide_cs0_n[0], ide_cs1_n[0], ide_cs0_n[1] and ide_cs1_n[1] respectively. Bit 9 picks the port and bit 8 picks CS1 over CS0. At most one select is low at a time.
- R6: ide_da equals host address bits 4..2 and stays stable for the whole access.
- R7: When host address bit 6 is 1, the access uses L=11 and D=4 whatever the speed mode is.
- R8: Reads (host_rnw=1) drive ide_ior_n low, writes drive ide_iow_n low, and the two are never low together.
- R9: host_done is a single-clock pulse that appears on the edge where the select deasserts. For reads, host_rdata then holds the ide_din value sampled on that edge.
- R10: While the host strobe from a finished access is still high, no new access starts. Offsets outside the four windows and the speed register produce no select and no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_sel | input | 1 | Decoded select of this card |
| host_addr | input | 12 | Byte offset within the card |
| host_rnw | input | 1 | 1 = read, 0 = write |
| host_strb | input | 1 | Host access strobe, active high |
| host_wdata | input | 8 | Write data for the speed register |
| ide_din | input | 16 | Data read from the IDE bus |
| ide_cs0_n | output | 2 | Register-set-0 select per port, active low |
| ide_cs1_n | output | 2 | Register-set-1 select per port, active low |
| ide_da | output | 3 | IDE register address |
| ide_ior_n | output | 1 | IDE read strobe, active low |
| ide_iow_n | output | 1 | IDE write strobe, active low |
| host_done | output | 1 | One-clock end-of-access pulse |
| host_rdata | output | 16 | Captured read data or speed register value |

## Verification
Every output is a register, and the bench samples one nanosecond after each rising edge, counting samples from the start edge. The select shows low in samples 1 through L. The strobe first shows in sample D+1. host_done and the captured read data show in sample L+1, when the select is already high again. A speed register access completes in sample 1. The bench derives L and D from the select and strobe runs it sees, and compares them with its own mode table, using random modes, windows, directions and data mixed with directed slow-path, held-strobe and out-of-window cases.

// File: rtl/ide_tg_pkg.sv
package ide_tg_pkg;
  localparam int ADDR_W    = 12;
  localparam int DATA_W    = 16;
  localparam int NUM_PORTS = 2;
  localparam int MODE_W    = 3;
  localparam int CNT_W     = 4;
  localparam int DA_W      = 3;
  localparam logic [ADDR_W-1:0] SPEED_OFS = 12'h7FE;

  typedef struct packed {
    logic [CNT_W-1:0] sel_len;
    logic [CNT_W-1:0] strb_dly;
  } timing_t;

  localparam timing_t SLOW_TIMING = '{sel_len: 4'd11, strb_dly: 4'd4};

  function automatic timing_t mode_timing(input logic [MODE_W-1:0] m);
    timing_t t;
    case (m)
      3'd0:    t = '{sel_len: 4'd7,  strb_dly: 4'd2};
      3'd1:    t = '{sel_len: 4'd9,  strb_dly: 4'd3};
      3'd2:    t = '{sel_len: 4'd11, strb_dly: 4'd4};
      3'd3:    t = '{sel_len: 4'd5,  strb_dly: 4'd1};
      3'd4:    t = '{sel_len: 4'd5,  strb_dly: 4'd2};
      3'd5:    t = '{sel_len: 4'd5,  strb_dly: 4'd3};
      3'd6:    t = '{sel_len: 4'd15, strb_dly: 4'd4};
      default: t = '{sel_len: 4'd5,  strb_dly: 4'd1};
    endcase
    return t;
  endfunction
endpackage

// File: rtl/ide_addr_decode.sv
module ide_addr_decode
  import ide_tg_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_win,
  output logic              hit_spd,
  output logic              port_sel,
  output logic              set_sel,
  output logic [DA_W-1:0]   da,
  output logic              slow
);
  always_comb begin
    hit_win  = (addr[ADDR_W-1 -: 2] == 2'b10);
    hit_spd  = (addr == SPEED_OFS);
    port_sel = addr[9];
    set_sel  = addr[8];
    da       = addr[4:2];
    slow     = addr[6];
  end
endmodule

// File: rtl/ide_speed_reg.sv
module ide_speed_reg
  import ide_tg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_mode,
  output logic [MODE_W-1:0] mode
);
  logic [MODE_W-1:0] mode_d, mode_q;

  always_comb begin
    mode_d = mode_q;
    if (wr_en) mode_d = wr_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_d;
  end

  assign mode = mode_q;
endmodule

// File: rtl/ide_cycle_fsm.sv
module ide_cycle_fsm
  import ide_tg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  timing_t              tim,
  input  logic                 port_in,
  input  logic                 set_in,
  input  logic [DA_W-1:0]      da_in,
  input  logic                 rnw_in,
  output logic                 busy,
  output logic                 last,
  output logic                 rnw,
  output logic [NUM_PORTS-1:0] cs0_n,
  output logic [NUM_PORTS-1:0] cs1_n,
  output logic [DA_W-1:0]      da,
  output logic                 ior_n,
  output logic                 iow_n
);
  logic             busy_d, busy_q;
  logic [CNT_W-1:0] cnt_d, cnt_q;
  timing_t          tim_d, tim_q;
  logic             strb_d, strb_q;
  logic             port_d, port_q, set_d, set_q, rnw_d, rnw_q;
  logic [DA_W-1:0]  da_d, da_q;

  assign last = busy_q && (cnt_q == tim_q.sel_len);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    tim_d  = tim_q;
    strb_d = strb_q;
    port_d = port_q;
    set_d  = set_q;
    rnw_d  = rnw_q;
    da_d   = da_q;
    if (last) begin
      busy_d = 1'b0;
      strb_d = 1'b0;
    end else if (busy_q) begin
      cnt_d  = cnt_q + CNT_W'(1);
      strb_d = (cnt_d > tim_q.strb_dly);
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(1);
      tim_d  = tim;
      strb_d = (CNT_W'(1) > tim.strb_dly);
      port_d = port_in;
      set_d  = set_in;
      rnw_d  = rnw_in;
      da_d   = da_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      tim_q  <= '0;
      strb_q <= 1'b0;
      port_q <= 1'b0;
      set_q  <= 1'b0;
      rnw_q  <= 1'b1;
      da_q   <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      tim_q  <= tim_d;
      strb_q <= strb_d;
      port_q <= port_d;
      set_q  <= set_d;
      rnw_q  <= rnw_d;
      da_q   <= da_d;
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign cs0_n[p] = !(busy_q && (port_q == p[0]) && !set_q);
    assign cs1_n[p] = !(busy_q && (port_q == p[0]) &&  set_q);
  end

  assign busy  = busy_q;
  assign rnw   = rnw_q;
  assign da    = da_q;
  assign ior_n = !(strb_q &&  rnw_q);
  assign iow_n = !(strb_q && !rnw_q);
endmodule

// File: rtl/ide_strobe_gen.sv
module ide_strobe_gen
  import ide_tg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 card_sel,
  input  logic [ADDR_W-1:0]    host_addr,
  input  logic                 host_rnw,
  input  logic                 host_strb,
  input  logic [7:0]           host_wdata,
  input  logic [DATA_W-1:0]    ide_din,
  output logic [NUM_PORTS-1:0] ide_cs0_n,
  output logic [NUM_PORTS-1:0] ide_cs1_n,
  output logic [DA_W-1:0]      ide_da,
  output logic                 ide_ior_n,
  output logic                 ide_iow_n,
  output logic                 host_done,
  output logic [DATA_W-1:0]    host_rdata
);
  logic             hit_win, hit_spd, port_sel, set_sel, slow;
  logic [DA_W-1:0]  dec_da;
  logic [MODE_W-1:0] mode;
  logic             busy, last, acc_rnw;
  logic             start_any, acc_start, spd_start;
  logic             armed_d, armed_q, done_d, done_q;
  logic [DATA_W-1:0] rdata_d, rdata_q;
  timing_t          tim_sel;
  logic             unused_wdata;

  assign unused_wdata = ^host_wdata[4:0];

  ide_addr_decode i_dec (
    .addr     (host_addr),
    .hit_win  (hit_win),
    .hit_spd  (hit_spd),
    .port_sel (port_sel),
    .set_sel  (set_sel),
    .da       (dec_da),
    .slow     (slow)
  );

  assign start_any = armed_q && card_sel && host_strb && !busy;
  assign acc_start = start_any && hit_win;
  assign spd_start = start_any && hit_spd;

  ide_speed_reg i_spd (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (spd_start && !host_rnw),
    .wr_mode (host_wdata[7:5]),
    .mode    (mode)
  );

  assign tim_sel = slow ? SLOW_TIMING : mode_timing(mode);

  ide_cycle_fsm i_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (acc_start),
    .tim     (tim_sel),
    .port_in (port_sel),
    .set_in  (set_sel),
    .da_in   (dec_da),
    .rnw_in  (host_rnw),
    .busy    (busy),
    .last    (last),
    .rnw     (acc_rnw),
    .cs0_n   (ide_cs0_n),
    .cs1_n   (ide_cs1_n),
    .da      (ide_da),
    .ior_n   (ide_ior_n),
    .iow_n   (ide_iow_n)
  );

  always_comb begin
    armed_d = armed_q;
    if (start_any)      armed_d = 1'b0;
    else if (!host_strb) armed_d = 1'b1;
    done_d  = last || spd_start;
    rdata_d = rdata_q;
    if (spd_start && host_rnw)
      rdata_d = {{(DATA_W-8){1'b0}}, mode, 5'b11111};
    else if (last && acc_rnw)
      rdata_d = ide_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      armed_q <= armed_d;
      done_q  <= done_d;
      rdata_q <= rdata_d;
    end
  end

  assign host_done  = done_q;
  assign host_rdata = rdata_q;
endmodule

// File: rtl/ide_strobe_gen_chk.sv
module ide_strobe_gen_chk
  import ide_tg_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_PORTS-1:0] ide_cs0_n,
  input logic [NUM_PORTS-1:0] ide_cs1_n,
  input logic [DA_W-1:0]      ide_da,
  input logic                 ide_ior_n,
  input logic                 ide_iow_n,
  input logic                 host_done
);
  logic sel_any, strb_any;
  logic [CNT_W:0] run_q;

  assign sel_any  = !(&ide_cs0_n) || !(&ide_cs1_n);
  assign strb_any = !ide_ior_n || !ide_iow_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_q <= '0;
    else if (sel_any) run_q <= run_q + 1'b1;
    else              run_q <= '0;
  end

  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ide_ior_n && !ide_iow_n));
  assert_strobe_in_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strb_any |-> sel_any);
  assert_strobe_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strb_any |=> (strb_any || !sel_any));
  assert_done_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_any) |-> host_done);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |=> !host_done);
  assert_cs_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~ide_cs0_n, ~ide_cs1_n}));
  assert_da_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_any && $past(sel_any)) |-> $stable(ide_da));
  assert_max_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= (CNT_W+1)'(15));
endmodule

bind ide_strobe_gen ide_strobe_gen_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ide_cs0_n (ide_cs0_n),
  .ide_cs1_n (ide_cs1_n),
  .ide_da    (ide_da),
  .ide_ior_n (ide_ior_n),
  .ide_iow_n (ide_iow_n),
  .host_done (host_done)
);

// File: tb/test_ide_strobe_gen.sv
`timescale 1ns/1ps
module test_ide_strobe_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        card_sel = 1'b0;
  logic [11:0] host_addr = '0;
  logic        host_rnw = 1'b1;
  logic        host_strb = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [15:0] ide_din = '0;
  logic [1:0]  ide_cs0_n, ide_cs1_n;
  logic [2:0]  ide_da;
  logic        ide_ior_n, ide_iow_n, host_done;
  logic [15:0] host_rdata;

  int n_chk = 0;
  int n_bad = 0;
  int cur_mode = 0;

  always #5 clk = ~clk;

  ide_strobe_gen i_ide_strobe_gen (
    .clk(clk), .rst_n(rst_n), .card_sel(card_sel), .host_addr(host_addr),
    .host_rnw(host_rnw), .host_strb(host_strb), .host_wdata(host_wdata),
    .ide_din(ide_din), .ide_cs0_n(ide_cs0_n), .ide_cs1_n(ide_cs1_n),
    .ide_da(ide_da), .ide_ior_n(ide_ior_n), .ide_iow_n(ide_iow_n),
    .host_done(host_done), .host_rdata(host_rdata)
  );

  function automatic int exp_len(input int m, input bit a6);
    int t [8] = '{7, 9, 11, 5, 5, 5, 15, 5};
    return a6 ? 11 : t[m];
  endfunction

  function automatic int exp_dly(input int m, input bit a6);
    int t [8] = '{2, 3, 4, 1, 2, 3, 4, 1};
    return a6 ? 4 : t[m];
  endfunction

  // expected active-low select code {cs1_n, cs0_n} for a window offset
  function automatic logic [3:0] exp_cs(input logic [11:0] a);
    logic [3:0] c = 4'b1111;
    if (a[8]) c[2 + a[9]] = 1'b0;
    else      c[a[9]]     = 1'b0;
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // measured results of one host access
  int          m_len, m_dly, m_done, m_ior, m_iow;
  logic [3:0]  m_cs;
  logic [2:0]  m_da;
  bit          m_da_ok;

  task automatic do_access(input logic [11:0] a, input bit rnw, input logic [7:0] wd,
                           input int limit, input bit hold);
    m_len = 0; m_dly = -1; m_done = -1; m_ior = 0; m_iow = 0;
    m_cs = 4'b1111; m_da = '0; m_da_ok = 1'b1;
    @(negedge clk);
    card_sel = 1'b1; host_addr = a; host_rnw = rnw; host_wdata = wd; host_strb = 1'b1;
    for (int i = 1; i <= limit; i++) begin
      @(posedge clk); #1;
      if (!(&ide_cs0_n) || !(&ide_cs1_n)) begin
        if (m_len == 0) begin m_cs = {ide_cs1_n, ide_cs0_n}; m_da = ide_da; end
        else if (ide_da != m_da) m_da_ok = 1'b0;
        m_len++;
      end
      if ((!ide_ior_n || !ide_iow_n) && m_dly < 0) m_dly = i - 1;
      if (!ide_ior_n) m_ior++;
      if (!ide_iow_n) m_iow++;
      if (host_done && m_done < 0) begin
        m_done = i;
        if (!hold) break;
      end
    end
    @(negedge clk);
    host_strb = 1'b0; card_sel = 1'b0;
    @(negedge clk);
  endtask

  task automatic write_mode(input int m);
    do_access(12'h7FE, 1'b0, {m[2:0], 5'b11111}, 4, 1'b0);
    check(m_done == 1, "R2 write done", m_done, 1);
    cur_mode = m;
  endtask

  task automatic window_access(input logic [11:0] a, input bit rnw, input string tag);
    int el = exp_len(cur_mode, a[6]);
    int ed = exp_dly(cur_mode, a[6]);
    ide_din = 16'($urandom);
    do_access(a, rnw, 8'h00, 40, 1'b0);
    check(m_len == el, {"R3/R7 select length ", tag}, m_len, el);
    check(m_dly == ed, {"R3/R7 strobe delay ", tag}, m_dly, ed);
    check(m_done == el + 1, {"R9 done position ", tag}, m_done, el + 1);
    check((rnw ? m_ior : m_iow) == el - ed, {"R4 strobe span ", tag}, rnw ? m_ior : m_iow, el - ed);
    check((rnw ? m_iow : m_ior) == 0, {"R8 wrong strobe ", tag}, rnw ? m_iow : m_ior, 0);
    check(m_cs == exp_cs(a), {"R5 select line ", tag}, m_cs, exp_cs(a));
    check(m_da == a[4:2] && m_da_ok, {"R6 register address ", tag}, m_da, a[4:2]);
    if (rnw) check(host_rdata == ide_din, {"R9 read data ", tag}, host_rdata, ide_din);
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(ide_cs0_n == 2'b11 && ide_cs1_n == 2'b11, "R1 selects in reset", {ide_cs1_n, ide_cs0_n}, 4'hF);
    check(ide_ior_n && ide_iow_n && !host_done, "R1 strobes in reset", {ide_ior_n, ide_iow_n, host_done}, 3'b110);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1, R2: reset mode readback
    do_access(12'h7FE, 1'b1, 8'h00, 4, 1'b0);
    check(m_done == 1, "R2 read done", m_done, 1);
    check(host_rdata == 16'h001F, "R1 reset mode readback", host_rdata, 16'h001F);

    // R3 default mode 0
    window_access(12'h800, 1'b1, "mode0 read");
    window_access(12'h91C, 1'b0, "mode0 write");

    // every mode, readback and timing
    for (int m = 0; m < 8; m++) begin
      write_mode(m);
      do_access(12'h7FE, 1'b1, 8'h00, 4, 1'b0);
      check(host_rdata == 16'({m[2:0], 5'b11111}), "R2 mode readback", host_rdata, {m[2:0], 5'b11111});
      window_access(12'hA08, 1'b1, "mode sweep");
      window_access(12'hB14, 1'b0, "mode sweep write");
    end

    // R7 slow path in a fast mode and a slow mode
    write_mode(3);
    window_access(12'h840, 1'b1, "R7 slow fast-mode");
    write_mode(6);
    window_access(12'hB5C, 1'b0, "R7 slow slow-mode");

    // R10 held strobe: no second access
    write_mode(3);
    do_access(12'h900, 1'b1, 8'h00, 14, 1'b1);
    check(m_len == 5, "R10 single access under held strobe", m_len, 5);
    check(m_done == 6, "R10 single done under held strobe", m_done, 6);

    // R10 out-of-window offsets
    do_access(12'hC40, 1'b1, 8'h00, 20, 1'b0);
    check(m_len == 0 && m_done < 0, "R10 offset C40 ignored", m_len, 0);
    do_access(12'h400, 1'b0, 8'h00, 20, 1'b0);
    check(m_len == 0 && m_done < 0, "R10 offset 400 ignored", m_len, 0);
    do_access(12'h7FE, 1'b1, 8'h00, 4, 1'b0);
    check(host_rdata == 16'h007F, "R10 mode unchanged", host_rdata, 16'h007F);

    // random mix
    void'($urandom(32'h1DE5EED));
    for (int k = 0; k < 40; k++) begin
      if ($urandom_range(0, 3) == 0) write_mode($urandom_range(0, 7));
      window_access(12'h800 | 12'($urandom_range(0, 1023)), 1'($urandom_range(0, 1)), "random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule